// File: doc/BRIEF.md
# Balanced-Ternary Cascaded Bridge Modulator

This block turns a signed level command into switch gate patterns for one phase of an inverter built from three series-connected H-bridges. The bridges carry voltage weights of 1, 3 and 9, so the phase can reach every integer level from -13 to +13. The command is split into balanced-ternary digits (-1, 0, +1), one per bridge. Each digit selects one of the three bridge states, and each bridge state has one fixed four-switch gate pattern. Each of the 27 levels has exactly one digit set, so no level has two switch settings.

A fault code tells the block which physical bridge has failed. The failed bridge is parked in its zero-output pattern. If a larger bridge fails, the smallest bridge takes over that bridge's weight, and the phase runs on two bridges at a 3-unit step. If the smallest bridge fails, it is only isolated, and the two larger bridges keep the gating they would have had without the fault. All outputs are registered and change only on a sample strobe.

Top module: `tern_bridge_mod`

## Requirements
- R1: While reset is asserted, and until the first sample strobe after reset, every bridge shows the zero-output pattern, so `gate_o` = 12'h555.
- R2: Bridge k drives `gate_o[4k+3:4k]`. Bit 3 is the upper-left switch, bit 2 the lower-left, bit 1 the upper-right and bit 0 the lower-right. State +1 is 4'b1001, state -1 is 4'b0110 and state 0 is 4'b0101. No other pattern ever appears.
- R3: With fault code 0, the bridges have weights 1, 3 and 9 for k = 0, 1 and 2. For any command from -13 to +13, the weighted sum of the bridge states equals the command.
- R4: With fault code 0, commands above +13 give level +13 (12'h999) and commands below -13 give level -13 (12'h666).
- R5: A command and fault code are taken on a rising edge where `sample_en` is high, and `gate_o` shows the result after that edge. Without the strobe, `gate_o` keeps its value whatever the other inputs do.
- R6: Fault code 1 marks bridge 0 as failed. Bridge 0 shows 4'b0101, and bridges 1 and 2 show exactly the patterns they would show under fault code 0 for the same command.
- R7: Fault code 2 marks bridge 1 as failed, and fault code 3 marks bridge 2 as failed. The failed bridge shows 4'b0101, and bridge 0 takes the failed bridge's weight (3 or 9). The phase level is the multiple of 3 nearest to the saturated command, so it lies within -12..+12.
- R8: No switch pair in the same leg (upper-left with lower-left, upper-right with lower-right) is ever on at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Strobe that loads a new command and fault code |
| level_cmd | input | 5 | Signed level command in two's complement |
| fault_code | input | 2 | 0 = no fault; k = physical bridge k-1 has failed |
| gate_o | output | 12 | Registered gate patterns, 4 bits per bridge |

## Verification
Every result is due one rising edge after the edge where `sample_en` is high, because there is exactly one register between the inputs and `gate_o`. The bench changes inputs on the falling edge, holds the strobe for one rising edge, and reads `gate_o` on the next falling edge. The hold check changes the command and fault code with the strobe low and reads `gate_o` several edges later. The reset checks read `gate_o` while reset is still held low, since the clear is asynchronous.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  // bridge state, one per balanced-ternary digit
  typedef enum logic [1:0] {
    TD_ZERO = 2'b00,
    TD_POS  = 2'b01,
    TD_NEG  = 2'b10
  } tdig_e;

  localparam int unsigned GATES_PER_BRIDGE = 4;
  // bit3 upper-left, bit2 lower-left, bit1 upper-right, bit0 lower-right
  localparam logic [3:0] GATE_POS = 4'b1001;
  localparam logic [3:0] GATE_NEG = 4'b0110;
  localparam logic [3:0] GATE_OFF = 4'b0101;
endpackage

// File: rtl/tbm_level_sat.sv
module tbm_level_sat #(
  parameter int unsigned LVL_W   = 5,
  parameter int          LVL_MAX = 13,
  parameter int unsigned OFS_W   = 5
) (
  input  logic signed [LVL_W-1:0] cmd_i,
  output logic        [OFS_W-1:0] ofs_o
);
  int lvl_v;
  int clip_v;

  always_comb begin
    lvl_v = int'(cmd_i);
    if (lvl_v > LVL_MAX) begin
      clip_v = LVL_MAX;
    end else if (lvl_v < -LVL_MAX) begin
      clip_v = -LVL_MAX;
    end else begin
      clip_v = lvl_v;
    end
    // shift to 0 .. 2*LVL_MAX so that plain base-3 digits appear
    ofs_o = OFS_W'(clip_v + LVL_MAX);
  end
endmodule

// File: rtl/tbm_digit_split.sv
module tbm_digit_split
  import tbm_pkg::*;
#(
  parameter int unsigned N_BRIDGE = 3,
  parameter int unsigned OFS_W    = 5
) (
  input  logic  [OFS_W-1:0]    ofs_i,
  output tdig_e [N_BRIDGE-1:0] dig_o
);
  for (genvar i = 0; i < N_BRIDGE; i++) begin : g_trit
    localparam int unsigned PLACE = 3 ** i;
    logic [31:0] trit;
    always_comb begin
      trit = (32'(ofs_i) / PLACE) % 32'd3;
      // unsigned digit 0/1/2 maps to balanced digit -1/0/+1
      if (trit == 32'd0) begin
        dig_o[i] = TD_NEG;
      end else if (trit == 32'd1) begin
        dig_o[i] = TD_ZERO;
      end else begin
        dig_o[i] = TD_POS;
      end
    end
  end
endmodule

// File: rtl/tbm_role_map.sv
module tbm_role_map
  import tbm_pkg::*;
#(
  parameter int unsigned N_BRIDGE = 3,
  parameter int unsigned FW       = 2
) (
  input  tdig_e [N_BRIDGE-1:0] dig_i,
  input  logic  [FW-1:0]       fault_code_i,
  output tdig_e [N_BRIDGE-1:0] dig_o
);
  tdig_e moved;

  always_comb begin
    // digit that the flexible bridge 0 takes over from a failed larger bridge
    moved = TD_ZERO;
    for (int k = 1; k < N_BRIDGE; k++) begin
      if (fault_code_i == FW'(k + 1)) begin
        moved = dig_i[k];
      end
    end
    for (int b = 0; b < N_BRIDGE; b++) begin
      if (fault_code_i == FW'(b + 1)) begin
        dig_o[b] = TD_ZERO;
      end else if ((b == 0) && (fault_code_i != '0)) begin
        dig_o[b] = moved;
      end else begin
        dig_o[b] = dig_i[b];
      end
    end
  end
endmodule

// File: rtl/tbm_gate_enc.sv
module tbm_gate_enc
  import tbm_pkg::*;
(
  input  tdig_e      dig_i,
  output logic [3:0] gate_o
);
  always_comb begin
    case (dig_i)
      TD_POS:  gate_o = GATE_POS;
      TD_NEG:  gate_o = GATE_NEG;
      default: gate_o = GATE_OFF;
    endcase
  end
endmodule

// File: rtl/tern_bridge_mod.sv
module tern_bridge_mod
  import tbm_pkg::*;
#(
  parameter int unsigned N_BRIDGE = 3,
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned FW       = $clog2(N_BRIDGE + 1)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   sample_en,
  input  logic signed [LVL_W-1:0]                level_cmd,
  input  logic        [FW-1:0]                   fault_code,
  output logic        [N_BRIDGE*GATES_PER_BRIDGE-1:0] gate_o
);
  localparam int          LVL_MAX = (3 ** N_BRIDGE - 1) / 2;
  localparam int unsigned OFS_W   = $clog2(2 * LVL_MAX + 1);
  localparam int unsigned GW      = N_BRIDGE * GATES_PER_BRIDGE;

  logic  [OFS_W-1:0]    ofs;
  tdig_e [N_BRIDGE-1:0] dig_raw;
  tdig_e [N_BRIDGE-1:0] dig_role;
  logic  [GW-1:0]       gate_enc;
  logic  [GW-1:0]       gate_d;
  logic  [GW-1:0]       gate_q;

  tbm_level_sat #(
    .LVL_W   (LVL_W),
    .LVL_MAX (LVL_MAX),
    .OFS_W   (OFS_W)
  ) u_sat (
    .cmd_i (level_cmd),
    .ofs_o (ofs)
  );

  tbm_digit_split #(
    .N_BRIDGE (N_BRIDGE),
    .OFS_W    (OFS_W)
  ) u_split (
    .ofs_i (ofs),
    .dig_o (dig_raw)
  );

  tbm_role_map #(
    .N_BRIDGE (N_BRIDGE),
    .FW       (FW)
  ) u_role (
    .dig_i        (dig_raw),
    .fault_code_i (fault_code),
    .dig_o        (dig_role)
  );

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_enc
    tbm_gate_enc u_enc (
      .dig_i  (dig_role[b]),
      .gate_o (gate_enc[b*GATES_PER_BRIDGE +: GATES_PER_BRIDGE])
    );
  end

  // next-state: load on strobe, else hold
  always_comb begin
    if (sample_en) begin
      gate_d = gate_enc;
    end else begin
      gate_d = gate_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= {N_BRIDGE{GATE_OFF}};
    end else begin
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/tbm_mod_chk.sv
module tbm_mod_chk
  import tbm_pkg::*;
#(
  parameter int unsigned N_BRIDGE = 3,
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned FW       = 2
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   sample_en,
  input logic signed [LVL_W-1:0]                level_cmd,
  input logic        [FW-1:0]                   fault_code,
  input logic        [N_BRIDGE*GATES_PER_BRIDGE-1:0] gate_o
);
  localparam int LVL_MAX = (3 ** N_BRIDGE - 1) / 2;

  function automatic int phase_level(input logic [N_BRIDGE*GATES_PER_BRIDGE-1:0] g);
    int acc;
    int wt;
    acc = 0;
    wt  = 1;
    for (int b = 0; b < N_BRIDGE; b++) begin
      if (g[b*GATES_PER_BRIDGE +: GATES_PER_BRIDGE] == GATE_POS) acc = acc + wt;
      if (g[b*GATES_PER_BRIDGE +: GATES_PER_BRIDGE] == GATE_NEG) acc = acc - wt;
      wt = wt * 3;
    end
    return acc;
  endfunction

  int cmd_v;
  assign cmd_v = int'(level_cmd);

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_bridge
    // R8: one leg never has both switches on
    p_leg_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_o[b*4+3] && gate_o[b*4+2]) && !(gate_o[b*4+1] && gate_o[b*4]));

    // R6 / R7: a bridge named by the fault code is parked at zero output
    p_fault_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && (fault_code == FW'(b + 1))) |=>
        (gate_o[b*4 +: 4] == GATE_OFF));
  end

  // R5: no strobe, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(gate_o));

  // R3: weighted sum tracks an in-range command
  p_level_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && (fault_code == '0) && (cmd_v <= LVL_MAX) && (cmd_v >= -LVL_MAX)) |=>
      (phase_level(gate_o) == $past(cmd_v)));

  // R4: over-range commands clip to the end levels
  p_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && (fault_code == '0) && (cmd_v > LVL_MAX)) |=>
      (phase_level(gate_o) == LVL_MAX));

  p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && (fault_code == '0) && (cmd_v < -LVL_MAX)) |=>
      (phase_level(gate_o) == -LVL_MAX));
endmodule

bind tern_bridge_mod tbm_mod_chk #(
  .N_BRIDGE (N_BRIDGE),
  .LVL_W    (LVL_W),
  .FW       (FW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_en  (sample_en),
  .level_cmd  (level_cmd),
  .fault_code (fault_code),
  .gate_o     (gate_o)
);

// File: tb/tern_bridge_mod_tb.sv
`timescale 1ns/1ps
module tern_bridge_mod_tb;
  logic              clk;
  logic              rst_n;
  logic              sample_en;
  logic signed [4:0] level_cmd;
  logic [1:0]        fault_code;
  logic [11:0]       gate_o;

  int n_chk;
  int n_bad;
  bit done;

  tern_bridge_mod u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .level_cmd  (level_cmd),
    .fault_code (fault_code),
    .gate_o     (gate_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vectors: fault code, command, expected phase level
  localparam int NV = 31;
  localparam int VF [NV] = '{0,0,0,0,0,0,0,0,0,0,0,
                             3,3,3,3,3,3,3,3,3,3,
                             2,2,2,2,2,2,
                             1,1,1,1};
  localparam int VC [NV] = '{0,1,-1,5,-7,13,-13,15,-16,4,-11,
                             13,-13,2,-2,4,5,0,15,7,-8,
                             1,-1,10,11,-5,-16,
                             13,5,-4,1};
  localparam int VE [NV] = '{0,1,-1,5,-7,13,-13,13,-13,4,-11,
                             12,-12,3,-3,3,6,0,12,6,-9,
                             0,0,9,12,-6,-12,
                             12,6,-3,0};

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // pattern to state; returns 2 for a pattern outside the three legal ones
  function automatic int pat_state(input logic [3:0] p);
    if (p == 4'b1001) return 1;
    if (p == 4'b0110) return -1;
    if (p == 4'b0101) return 0;
    return 2;
  endfunction

  function automatic int role_weight(input int fc, input int b);
    int w [4][3] = '{'{1,3,9}, '{0,3,9}, '{3,0,9}, '{9,3,0}};
    return w[fc][b];
  endfunction

  task automatic strobe(input int fc, input int cmd);
    @(negedge clk);
    fault_code = 2'(fc);
    level_cmd  = 5'(cmd);
    sample_en  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample_en  = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    sample_en = 1'b0;
    level_cmd = '0;
    fault_code = '0;
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    repeat (3) @(negedge clk);
    check(gate_o == 12'h555, "R1 in reset", int'(gate_o), 32'h555);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(gate_o == 12'h555, "R1 after release", int'(gate_o), 32'h555);

    // table walk
    for (int i = 0; i < NV; i++) begin
      int lvl;
      int st;
      bit legal;
      strobe(VF[i], VC[i]);
      lvl = 0;
      legal = 1'b1;
      for (int b = 0; b < 3; b++) begin
        st = pat_state(gate_o[b*4 +: 4]);
        if (st == 2) legal = 1'b0;
        else lvl = lvl + st * role_weight(VF[i], b);
      end
      check(legal, "R2 legal patterns", int'(gate_o), 0);
      if (VF[i] == 0) begin
        if (VC[i] > 13 || VC[i] < -13)
          check(lvl == VE[i], "R4 saturation", lvl, VE[i]);
        else
          check(lvl == VE[i], "R3 level sum", lvl, VE[i]);
      end else begin
        check(gate_o[(VF[i]-1)*4 +: 4] == 4'b0101, "R7 failed bridge parked",
              int'(gate_o[(VF[i]-1)*4 +: 4]), 5);
        check(lvl == VE[i], "R7 reduced level", lvl, VE[i]);
      end
    end

    // R4 exact patterns at the ends
    strobe(0, 14);
    check(gate_o == 12'h999, "R4 top pattern", int'(gate_o), 32'h999);
    strobe(0, -14);
    check(gate_o == 12'h666, "R4 bottom pattern", int'(gate_o), 32'h666);

    // R2 single-bridge encodings: +1 on bridge 0 only, -1 on bridge 1 only
    strobe(0, 1);
    check(gate_o == 12'h559, "R2 plus pattern", int'(gate_o), 32'h559);
    strobe(0, -3);
    check(gate_o == 12'h565, "R2 minus pattern", int'(gate_o), 32'h565);

    // R6: bridges 1 and 2 unchanged versus fault-free
    foreach (VC[j]) begin
      logic [11:0] ref_g;
      if (j < 11 && VC[j] >= -13 && VC[j] <= 13) begin
        strobe(0, VC[j]);
        ref_g = gate_o;
        strobe(1, VC[j]);
        check(gate_o[11:4] == ref_g[11:4], "R6 larger bridges keep gating",
              int'(gate_o[11:4]), int'(ref_g[11:4]));
        check(gate_o[3:0] == 4'b0101, "R6 smallest parked", int'(gate_o[3:0]), 5);
      end
    end

    // R5: inputs move without strobe, output holds
    strobe(0, 7);
    begin
      logic [11:0] held;
      held = gate_o;
      @(negedge clk);
      level_cmd = -5'sd9;
      fault_code = 2'd3;
      repeat (4) @(negedge clk);
      check(gate_o == held, "R5 hold without strobe", int'(gate_o), int'(held));
      // one strobe edge then the new value is due
      sample_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sample_en = 1'b0;
      // code 3, command -9: bridge0 weight 9 = -1, bridge1 0, bridge2 parked
      check(gate_o == 12'h556, "R5 update after strobe", int'(gate_o), 32'h556);
    end

    // R1: asynchronous clear mid-run
    strobe(0, 13);
    #1 rst_n = 1'b0;
    #1 check(gate_o == 12'h555, "R1 async clear", int'(gate_o), 32'h555);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule